// File: doc/BRIEF.md
# Snooping Four-State Coherence Controller

This block keeps the coherence state of a small, fixed set of lines for one private write-back cache that sits on a shared snooping bus. Each tracked line is Invalid, Shared, Exclusive or Modified. The controller serves local processor reads and writes. It raises bus requests when it lacks a valid copy or lacks the right to write. It also watches the transactions that other caches win on the bus and adjusts its own copies in response.

The processor interface and the bus request interface are valid/ready pairs. A requester holds `cpu_valid`, `cpu_write` and `cpu_line` steady until it sees `cpu_ready` high at a clock edge. The controller holds `bus_valid`, `bus_op` and `bus_line` steady until the arbiter returns `bus_ready`. A granted bus transaction completes in its grant cycle. In that same cycle, every other cache sees it on its snoop inputs and answers with `snp_shared`, and with a write-back strobe if its copy is dirty. The OR of the other caches' `snp_shared` comes back to the requester as `bus_shared`. The arbiter grants at most one cache per cycle. The data array, memory and arbiter are outside the block.

Top module: `mesi_coh_ctrl`

## Requirements
- R1: After reset every tracked line is Invalid. `line_state` holds line i in bits [2i+1:2i], encoded I=0, S=1, E=2, M=3.
- R2: A read of a line in S, E or M completes with `cpu_ready` high in the same cycle, drives no bus request and leaves the state as it was.
- R3: A read of an Invalid line raises `bus_valid` with `bus_op`=0 (read). It completes in the cycle `bus_ready` is high. The line becomes E if `bus_shared` was low in that cycle, and S otherwise.
- R4: A write to an E line completes in the same cycle with no bus request, and the line becomes M.
- R5: A write to an S or I line raises `bus_valid` with `bus_op`=1 (read-for-ownership). It completes only in the grant cycle, and the line becomes M.
- R6: A snooped read-for-ownership turns any local copy of that line to I in the next cycle. `snp_shared` is high in the snoop cycle when a copy was held.
- R7: A snooped read of a line held in E or M turns it to S in the next cycle, with `snp_shared` high. A snooped read of an S line leaves it in S.
- R8: A snooped read or read-for-ownership of an M line raises `wb_valid`, with `wb_line` set to that line, in the snoop cycle, before the state leaves M.
- R9: A snoop takes priority over a local access. When a snoop targets the line the processor is accessing, `cpu_ready` stays low in that cycle. A local grant and a snoop never occur together.
- R10: While a request that needs the bus waits without `bus_ready`, `cpu_ready` stays low, `bus_valid` stays high and the line state does not change.
- R11: Across all caches on the bus, a line held in E or M by one cache is Invalid in every other cache in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor access request |
| cpu_ready | output | 1 | Access completes at this edge |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_line | input | LW | Tracked line index |
| bus_valid | output | 1 | Bus transaction request |
| bus_ready | input | 1 | Grant from the bus arbiter |
| bus_op | output | 1 | 0 = read, 1 = read-for-ownership |
| bus_line | output | LW | Line of the bus request |
| bus_shared | input | 1 | Some other cache holds the requested line |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_op | input | 1 | Snooped op, same code as `bus_op` |
| snp_line | input | LW | Snooped line |
| snp_shared | output | 1 | Local copy of the snooped line exists |
| wb_valid | output | 1 | Dirty data of `wb_line` is written back now |
| wb_line | output | LW | Line being written back |
| line_state | output | 2*NLINES | State of every tracked line |

## Verification
Hits (R2, R4) complete in the cycle they are presented. Misses and upgrades (R3, R5) complete in the grant cycle, so under contention the losing cache finishes one cycle later (R10). Snoop outputs (R6 to R8) are combinational in the snoop cycle, and the state effects are visible one edge later. The bench drives inputs on the falling edge and samples `cpu_ready`, bus and snoop outputs 1 ns later inside the completion cycle. It pushes the expected states of both caches into a queue, and a monitor compares them on the next falling edge, after the updating edge. The monitor also checks the single-owner invariant on every line in every cycle.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  localparam logic OP_RD  = 1'b0;
  localparam logic OP_RFO = 1'b1;
endpackage

// File: rtl/mesi_line.sv
module mesi_line
  import mesi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fill_en,
  input  mesi_t fill_st,
  input  logic  up_en,
  input  logic  snp_rd,
  input  logic  snp_rfo,
  output mesi_t state
);
  mesi_t nxt;

  always_comb begin
    nxt = state;
    if (snp_rfo)
      nxt = ST_I;
    else if (snp_rd && (state == ST_E || state == ST_M))
      nxt = ST_S;
    else if (fill_en)
      nxt = fill_st;
    else if (up_en)
      nxt = ST_M;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_I;
    else        state <= nxt;
  end

  // R6: snooped ownership request drops the copy
  a_r6_rfo_inval: assert property (@(posedge clk) disable iff (!rst_n)
    snp_rfo |=> state == ST_I);

  // R7: snooped read demotes an owner to shared
  a_r7_rd_demote: assert property (@(posedge clk) disable iff (!rst_n)
    snp_rd && (state == ST_E || state == ST_M) |=> state == ST_S);

  // R4: silent upgrade of an exclusive line
  a_r4_silent_up: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && state == ST_E && !snp_rd && !snp_rfo |=> state == ST_M);

  // R5: a line only enters M through a granted fill or an upgrade
  a_r5_m_entry: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_M && $past(state) != ST_M |-> $past(fill_en || up_en));
endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop
  import mesi_pkg::*;
#(
  parameter int NLINES = 4,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic [2*NLINES-1:0] st_flat,
  input  logic                snp_valid,
  input  logic                snp_op,
  input  logic [LW-1:0]       snp_line,
  output logic [NLINES-1:0]   rd_hit,
  output logic [NLINES-1:0]   rfo_hit,
  output logic                shared,
  output logic                wb_valid,
  output logic [LW-1:0]       wb_line
);
  mesi_t cur;

  assign cur      = mesi_t'(st_flat[2*snp_line +: 2]);
  assign shared   = snp_valid && cur != ST_I;
  assign wb_valid = snp_valid && cur == ST_M;
  assign wb_line  = snp_line;

  for (genvar i = 0; i < NLINES; i++) begin : g_dec
    logic sel;
    assign sel        = snp_valid && snp_line == LW'(i);
    assign rd_hit[i]  = sel && snp_op == OP_RD;
    assign rfo_hit[i] = sel && snp_op == OP_RFO;
  end
endmodule

// File: rtl/mesi_coh_ctrl.sv
module mesi_coh_ctrl
  import mesi_pkg::*;
#(
  parameter int NLINES = 4,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  output logic                cpu_ready,
  input  logic                cpu_write,
  input  logic [LW-1:0]       cpu_line,
  output logic                bus_valid,
  input  logic                bus_ready,
  output logic                bus_op,
  output logic [LW-1:0]       bus_line,
  input  logic                bus_shared,
  input  logic                snp_valid,
  input  logic                snp_op,
  input  logic [LW-1:0]       snp_line,
  output logic                snp_shared,
  output logic                wb_valid,
  output logic [LW-1:0]       wb_line,
  output logic [2*NLINES-1:0] line_state
);
  mesi_t              st [NLINES];
  logic [NLINES-1:0]  rd_hit, rfo_hit;
  mesi_t              cur, fill_st;
  logic               need_bus, snp_on_cpu, grant;

  assign cur        = st[cpu_line];
  assign snp_on_cpu = snp_valid && snp_line == cpu_line;
  assign need_bus   = cpu_write ? !(cur == ST_E || cur == ST_M) : (cur == ST_I);
  assign bus_valid  = cpu_valid && need_bus;
  assign bus_op     = cpu_write ? OP_RFO : OP_RD;
  assign bus_line   = cpu_line;
  assign grant      = bus_valid && bus_ready;
  assign cpu_ready  = cpu_valid && !snp_on_cpu && (!need_bus || bus_ready);
  assign fill_st    = cpu_write ? ST_M : (bus_shared ? ST_S : ST_E);

  mesi_snoop #(.NLINES(NLINES)) u_snoop (
    .st_flat  (line_state),
    .snp_valid(snp_valid),
    .snp_op   (snp_op),
    .snp_line (snp_line),
    .rd_hit   (rd_hit),
    .rfo_hit  (rfo_hit),
    .shared   (snp_shared),
    .wb_valid (wb_valid),
    .wb_line  (wb_line)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic here;
    assign here = cpu_line == LW'(i);
    mesi_line u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .fill_en(grant && here),
      .fill_st(fill_st),
      .up_en  (cpu_ready && cpu_write && !need_bus && here),
      .snp_rd (rd_hit[i]),
      .snp_rfo(rfo_hit[i]),
      .state  (st[i])
    );
    assign line_state[2*i +: 2] = st[i];
  end

  // R9: one bus transaction per cycle, snoop never alongside own grant
  a_r9_one_txn: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && snp_valid));

  // R9: a snoop on the accessed line holds the local access off
  a_r9_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && cpu_valid && snp_line == cpu_line |-> !cpu_ready);

  // R5: a completed write leaves the line writable and dirty
  a_r5_wr_done: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_write |=> st[$past(cpu_line)] == ST_M);

  // R3: a completed read leaves a valid copy
  a_r3_rd_done: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !cpu_write |=> st[$past(cpu_line)] != ST_I);

  // R8: after the write-back strobe the line is no longer dirty
  a_r8_wb_clean: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> st[$past(wb_line)] != ST_M);

  // R10: a waiting request changes nothing
  a_r10_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready && !snp_valid |=> st[$past(cpu_line)] == $past(cur));
endmodule

// File: tb/test_mesi_coh_ctrl.sv
module test_mesi_coh_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       cv [2];
  logic       cw [2];
  logic [1:0] cl [2];

  logic       a_rdy, b_rdy, a_bv, b_bv, a_op, b_op, a_shr, b_shr, a_wbv, b_wbv;
  logic [1:0] a_bl, b_bl, a_wbl, b_wbl;
  logic [7:0] a_st, b_st;
  logic       a_gnt, b_gnt;

  assign a_gnt = a_bv;
  assign b_gnt = b_bv && !a_bv;

  mesi_coh_ctrl #(.NLINES(4)) i_mesi_coh_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cv[0]), .cpu_ready(a_rdy), .cpu_write(cw[0]), .cpu_line(cl[0]),
    .bus_valid(a_bv), .bus_ready(a_gnt), .bus_op(a_op), .bus_line(a_bl),
    .bus_shared(b_shr),
    .snp_valid(b_gnt), .snp_op(b_op), .snp_line(b_bl), .snp_shared(a_shr),
    .wb_valid(a_wbv), .wb_line(a_wbl), .line_state(a_st)
  );

  mesi_coh_ctrl #(.NLINES(4)) i_mesi_coh_ctrl_b (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cv[1]), .cpu_ready(b_rdy), .cpu_write(cw[1]), .cpu_line(cl[1]),
    .bus_valid(b_bv), .bus_ready(b_gnt), .bus_op(b_op), .bus_line(b_bl),
    .bus_shared(a_shr),
    .snp_valid(a_gnt), .snp_op(a_op), .snp_line(a_bl), .snp_shared(b_shr),
    .wb_valid(b_wbv), .wb_line(b_wbl), .line_state(b_st)
  );

  typedef struct {
    string tag;
    int    ln;
    int    ea, eb;
    bit    ebus, abus, ewb, awb, eshr, ashr;
    int    ewait, await_n;
  } item_t;

  item_t q [$];
  int total = 0;
  int bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit rdy_of(input int who);
    return who == 0 ? a_rdy : b_rdy;
  endfunction

  // driver: presents one access, records what it saw, queues the expectation
  task automatic access(input int who, input bit wr, input int ln,
                        input int ea, input int eb, input bit ebus,
                        input bit ewb, input bit eshr, input int ewait,
                        input string tag);
    item_t it;
    int w;
    w = 0;
    @(negedge clk);
    cv[who] = 1'b1; cw[who] = wr; cl[who] = 2'(ln);
    forever begin
      #1;
      if (rdy_of(who) || w > 40) break;
      @(negedge clk);
      w++;
    end
    it.tag = tag; it.ln = ln; it.ea = ea; it.eb = eb;
    it.ebus = ebus; it.ewb = ewb; it.eshr = eshr; it.ewait = ewait;
    it.await_n = w;
    if (who == 0) begin
      it.abus = a_bv; it.ashr = b_shr; it.awb = b_wbv && b_wbl == 2'(ln);
    end else begin
      it.abus = b_bv; it.ashr = a_shr; it.awb = a_wbv && a_wbl == 2'(ln);
    end
    q.push_back(it);
    @(posedge clk);
    #1 cv[who] = 1'b0;
  endtask

  // monitor: compares queued expectations after the updating edge, and R11 each cycle
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0) begin
        item_t it;
        int sa, sb;
        it = q.pop_front();
        sa = int'(a_st[2*it.ln +: 2]);
        sb = int'(b_st[2*it.ln +: 2]);
        chk(sa == it.ea, it.tag, "state cache A", sa, it.ea);
        chk(sb == it.eb, it.tag, "state cache B", sb, it.eb);
        chk(it.abus == it.ebus, it.tag, "bus request", it.abus, it.ebus);
        chk(it.awb == it.ewb, it.tag, "write-back", it.awb, it.ewb);
        chk(it.ashr == it.eshr, it.tag, "shared response", it.ashr, it.eshr);
        chk(it.await_n == it.ewait, it.tag, "wait cycles", it.await_n, it.ewait);
      end
      for (int l = 0; l < 4; l++) begin
        int sa, sb;
        bit ok;
        sa = int'(a_st[2*l +: 2]);
        sb = int'(b_st[2*l +: 2]);
        ok = !((sa >= 2 && sb != 0) || (sb >= 2 && sa != 0));
        chk(ok, "R11", "owner invariant A*4+B", sa*4 + sb, 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 5000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cv[0] = 0; cv[1] = 0; cw[0] = 0; cw[1] = 0; cl[0] = 0; cl[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(a_st == 8'h00, "R1", "reset state A", int'(a_st), 0);
    chk(b_st == 8'h00, "R1", "reset state B", int'(b_st), 0);

    // codes: I=0 S=1 E=2 M=3
    access(0, 0, 0, 2, 0, 1, 0, 0, 0, "R3");      // read miss, no sharer -> E
    access(0, 1, 0, 3, 0, 0, 0, 0, 0, "R4");      // silent upgrade
    access(1, 0, 0, 1, 1, 1, 1, 1, 0, "R7 R8");   // A M: write-back, both S
    access(1, 1, 0, 0, 3, 1, 0, 1, 0, "R5 R6");   // upgrade from S, A invalidated
    access(0, 1, 0, 3, 0, 1, 1, 1, 0, "R5 R6 R8");// write from I, B M drops with wb
    access(1, 0, 1, 0, 2, 1, 0, 0, 0, "R3");      // B exclusive
    access(0, 0, 1, 1, 1, 1, 0, 1, 0, "R3 R7");   // shared fill, E demoted
    access(0, 0, 1, 1, 1, 0, 0, 0, 0, "R2");      // read hit on S
    access(0, 1, 1, 3, 0, 1, 0, 1, 0, "R5 R6");   // upgrade from S
    // contention: A wins, B waits one cycle
    fork
      access(0, 1, 2, 3, 0, 1, 0, 0, 0, "R5");
      access(1, 0, 2, 1, 1, 1, 1, 1, 1, "R10 R8");
    join
    // snoop priority: A write hit on E collides with B read of same line
    access(0, 0, 3, 2, 0, 1, 0, 0, 0, "R3");
    fork
      access(0, 1, 3, 3, 0, 1, 0, 1, 1, "R9");
      access(1, 0, 3, 1, 1, 1, 0, 1, 0, "R9 R7");
    join
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule